// File: doc/BRIEF.md
# Sign-LMS Coefficient Update Unit

This block adapts the weights of an eight-tap equalizer with the sign-sign LMS rule. Each valid cycle it takes one equalized output sample from the first filter phase, together with the sign bit of the input sample held in every tap. A built-in three-level slicer turns the equalized sample into a decision, and the error is the sample minus that decision. Every tap then moves its weight one step up or one step down. Both candidate values are formed side by side, and the choice between them is the exclusive-OR of the error sign and that tap's input sign. No multiplier sits in the update loop.

The weights are 10-bit two's-complement words with 8 fractional bits, so 1.0 is the code 256. They saturate at +511 and -512 and never wrap. The step size is an input, so a controller outside the block can shift it from coarse to fine while the equalizer converges. An initialise input loads a fixed three-tap starting response, -K / 1.0 / -K, centred on tap 4 (taps are counted from 0), and clears the other taps. One coefficient set drives all filter phases.

Top module: `sign_lms_update`

## Requirements
- R1: While `rst` is high at a rising edge, the coefficients become 256 on tap 4 and 0 on every other tap. Tap i occupies bits `[i*10 +: 10]` of `coef_out`.
- R2: Each rising edge that sees `init` high loads taps 3 and 5 with the two's complement of `init_k` (unsigned magnitude) and tap 4 with 256. All other taps load 0. This takes priority over any update.
- R3: A sample is discarded and changes no tap if `init` is high at its capture edge or at the edge after it.
- R4: The slicer picks +256 if the sample (12-bit signed) is at least +128, picks -256 if it is at most -128, and picks 0 otherwise. The error is the sample minus that decision.
- R5: For a nonzero error, each tap takes the XOR of the error sign and `tap_sign[i]` (1 means negative). If the result is 1, the tap becomes its weight plus the step; if it is 0, the tap becomes its weight minus the step.
- R6: A sample whose error is exactly zero leaves every coefficient unchanged.
- R7: A sample captured at rising edge t changes `coef_out` at edge t+2 and not earlier. Edges without a valid sample cause no change.
- R8: Updates saturate at +511 and -512 instead of wrapping.
- R9: The step used for a sample is the `step` value present at that sample's capture edge.
- R10: All taps update on the same edge, and samples on consecutive cycles are each applied, in order, on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | A sample and its tap signs are present this cycle |
| eq_out | input | 12 | Equalized output of the first filter phase, signed |
| tap_sign | input | 8 | Sign bit of each tap's input sample, bit i for tap i |
| step | input | 6 | Unsigned step size in coefficient LSBs |
| init | input | 1 | Load the three-tap starting response |
| init_k | input | 9 | Magnitude K of the side taps of the starting response |
| coef_out | output | 80 | Registered coefficients, tap i at bits [i*10 +: 10] |

## Verification
A sample driven before capture edge t has two results due. The unchanged coefficients must still be present after edge t+1, and the updated ones must appear after edge t+2. An init pattern is due one edge after the edge that sees `init`. The driver task computes each expected vector and queues it together with the exact cycle count at which it is due. The monitor compares only on the falling edge whose cycle count matches, so every result is checked in its own cycle rather than at some later point.

// File: rtl/slms_pkg.sv
package slms_pkg;

  // Three-level slicer decision
  typedef enum logic [1:0] {
    DEC_ZERO = 2'd0,
    DEC_POS  = 2'd1,
    DEC_NEG  = 2'd2
  } slice_dec_t;

  // Error summary handed from the slicer to the tap cells
  typedef struct packed {
    logic vld;
    logic neg;
    logic zero;
  } err_flag_t;

  // Role a tap plays in the starting response
  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_MAIN = 2'd1,
    ROLE_SIDE = 2'd2
  } tap_role_t;

  function automatic tap_role_t tap_role(input int idx, input int main_idx);
    if (idx == main_idx)
      return ROLE_MAIN;
    else if (idx == main_idx - 1 || idx == main_idx + 1)
      return ROLE_SIDE;
    else
      return ROLE_IDLE;
  endfunction

endpackage

// File: rtl/slms_slicer.sv
module slms_slicer
  import slms_pkg::*;
#(
  parameter int YW  = 12,
  parameter int AMP = 256,
  parameter int MUW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           in_vld,
  input  logic [YW-1:0]  y_in,
  input  logic [MUW-1:0] step_in,
  output err_flag_t      err_o,
  output logic [MUW-1:0] step_o
);

  localparam int EW = YW + 1;
  localparam logic signed [EW-1:0] LVL  = EW'(AMP);
  localparam logic signed [EW-1:0] THR  = EW'(AMP / 2);
  localparam logic signed [EW-1:0] NTHR = -THR;

  // capture stage
  logic                 vld_q;
  logic [YW-1:0]        y_q;
  logic [MUW-1:0]       step_q;

  // decision
  slice_dec_t           dec;
  logic signed [EW-1:0] y_ext;
  logic signed [EW-1:0] level;
  logic signed [EW-1:0] err;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      y_q    <= '0;
      step_q <= '0;
    end else begin
      vld_q  <= in_vld & ~flush;
      y_q    <= y_in;
      step_q <= step_in;
    end
  end

  always_comb begin
    y_ext = {y_q[YW-1], y_q};
    if (y_ext >= THR)
      dec = DEC_POS;
    else if (y_ext <= NTHR)
      dec = DEC_NEG;
    else
      dec = DEC_ZERO;
    unique case (dec)
      DEC_POS: level = LVL;
      DEC_NEG: level = -LVL;
      default: level = '0;
    endcase
    err = y_ext - level;
  end

  // error-sign stage
  always_ff @(posedge clk) begin
    if (rst) begin
      err_o  <= '0;
      step_o <= '0;
    end else begin
      err_o.vld  <= vld_q & ~flush;
      err_o.neg  <= err[EW-1];
      err_o.zero <= (err == '0);
      step_o     <= step_q;
    end
  end

endmodule

// File: rtl/slms_tap_sign.sv
module slms_tap_sign #(
  parameter int NT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] sgn_in,
  output logic [NT-1:0] sgn_o
);

  logic [NT-1:0] sgn_q;

  // two registers so the signs line up with the error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      sgn_q <= '0;
      sgn_o <= '0;
    end else begin
      sgn_q <= sgn_in;
      sgn_o <= sgn_q;
    end
  end

endmodule

// File: rtl/slms_tap_cell.sv
module slms_tap_cell #(
  parameter int              CW      = 10,
  parameter int              MUW     = 6,
  parameter logic [CW-1:0]   RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_ld,
  input  logic [CW-1:0]  init_val,
  input  logic           upd_en,
  input  logic           up,
  input  logic [MUW-1:0] step,
  output logic [CW-1:0]  coef_o
);

  localparam int SW = CW + 1;
  localparam logic signed [SW-1:0] CMAX = SW'((1 << (CW - 1)) - 1);
  localparam logic signed [SW-1:0] CMIN = -CMAX - SW'(1);

  logic signed [SW-1:0] c_ext;
  logic signed [SW-1:0] mu_ext;
  logic signed [SW-1:0] sum_up;
  logic signed [SW-1:0] sum_dn;
  logic [CW-1:0]        cand_up;
  logic [CW-1:0]        cand_dn;

  // both candidates are formed every cycle; the sign product only selects
  always_comb begin
    c_ext   = {coef_o[CW-1], coef_o};
    mu_ext  = {{(SW - MUW){1'b0}}, step};
    sum_up  = c_ext + mu_ext;
    sum_dn  = c_ext - mu_ext;
    cand_up = (sum_up > CMAX) ? CMAX[CW-1:0] : sum_up[CW-1:0];
    cand_dn = (sum_dn < CMIN) ? CMIN[CW-1:0] : sum_dn[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      coef_o <= RST_VAL;
    else if (init_ld)
      coef_o <= init_val;
    else if (upd_en)
      coef_o <= up ? cand_up : cand_dn;
  end

endmodule

// File: rtl/sign_lms_update.sv
module sign_lms_update
  import slms_pkg::*;
#(
  parameter int NTAPS    = 8,
  parameter int CW       = 10,
  parameter int FRAC     = 8,
  parameter int YW       = 12,
  parameter int MUW      = 6,
  parameter int KW       = 9,
  parameter int AMP      = 256,
  parameter int MAIN_TAP = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_vld,
  input  logic [YW-1:0]       eq_out,
  input  logic [NTAPS-1:0]    tap_sign,
  input  logic [MUW-1:0]      step,
  input  logic                init,
  input  logic [KW-1:0]       init_k,
  output logic [NTAPS*CW-1:0] coef_out
);

  localparam logic [CW-1:0] UNITY = CW'(1 << FRAC);

  err_flag_t        err;
  logic [MUW-1:0]   step_al;
  logic [NTAPS-1:0] sgn_al;
  logic [CW-1:0]    k_neg;
  logic             upd;

  slms_slicer #(
    .YW  (YW),
    .AMP (AMP),
    .MUW (MUW)
  ) u_slicer (
    .clk     (clk),
    .rst     (rst),
    .flush   (init),
    .in_vld  (smp_vld),
    .y_in    (eq_out),
    .step_in (step),
    .err_o   (err),
    .step_o  (step_al)
  );

  slms_tap_sign #(
    .NT (NTAPS)
  ) u_sign (
    .clk    (clk),
    .rst    (rst),
    .sgn_in (tap_sign),
    .sgn_o  (sgn_al)
  );

  assign k_neg = '0 - CW'(init_k);
  assign upd   = err.vld & ~err.zero;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam tap_role_t     ROLE  = tap_role(i, MAIN_TAP);
    localparam logic [CW-1:0] RST_V = (ROLE == ROLE_MAIN) ? UNITY : '0;

    logic [CW-1:0] ival;

    if (ROLE == ROLE_MAIN) begin : g_main
      assign ival = UNITY;
    end else if (ROLE == ROLE_SIDE) begin : g_side
      assign ival = k_neg;
    end else begin : g_idle
      assign ival = '0;
    end

    slms_tap_cell #(
      .CW      (CW),
      .MUW     (MUW),
      .RST_VAL (RST_V)
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .init_ld  (init),
      .init_val (ival),
      .upd_en   (upd),
      .up       (err.neg ^ sgn_al[i]),
      .step     (step_al),
      .coef_o   (coef_out[i*CW +: CW])
    );
  end

endmodule

// File: rtl/slms_checker.sv
module slms_checker #(
  parameter int NTAPS    = 8,
  parameter int CW       = 10,
  parameter int FRAC     = 8,
  parameter int MUW      = 6,
  parameter int KW       = 9,
  parameter int MAIN_TAP = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_vld,
  input logic [MUW-1:0]      step,
  input logic                init,
  input logic [KW-1:0]       init_k,
  input logic [NTAPS*CW-1:0] coef_out
);

  localparam logic [CW-1:0] ONE_C = CW'(1 << FRAC);

  logic [NTAPS*CW-1:0] init_vec;
  logic [NTAPS*CW-1:0] rst_vec;

  function automatic int absd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    int d;
    d = int'($signed(a)) - int'($signed(b));
    return (d < 0) ? -d : d;
  endfunction

  for (genvar i = 0; i < NTAPS; i++) begin : g_pat
    if (i == MAIN_TAP) begin : g_m
      assign init_vec[i*CW +: CW] = ONE_C;
      assign rst_vec[i*CW +: CW]  = ONE_C;
    end else if (i == MAIN_TAP - 1 || i == MAIN_TAP + 1) begin : g_s
      assign init_vec[i*CW +: CW] = '0 - CW'(init_k);
      assign rst_vec[i*CW +: CW]  = '0;
    end else begin : g_z
      assign init_vec[i*CW +: CW] = '0;
      assign rst_vec[i*CW +: CW]  = '0;
    end
  end

  // R1: reset loads the unit-centre response
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> coef_out == rst_vec);

  // R2: init loads the three-tap pattern on the next edge
  a_r2_init_pattern: assert property (@(posedge clk) disable iff (rst)
    init |=> coef_out == $past(init_vec));

  // R7: no sample three edges back, no init or reset: nothing moves
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_vld, 3) && !$past(init) && !$past(rst)) |-> $stable(coef_out));

  // R5: a tap never moves by more than the step captured with its sample
  for (genvar i = 0; i < NTAPS; i++) begin : g_step
    a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(init)) |->
        absd(coef_out[i*CW +: CW], $past(coef_out[i*CW +: CW])) <= int'($past(step, 3)));
  end

endmodule

bind sign_lms_update slms_checker #(
  .NTAPS    (NTAPS),
  .CW       (CW),
  .FRAC     (FRAC),
  .MUW      (MUW),
  .KW       (KW),
  .MAIN_TAP (MAIN_TAP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .step     (step),
  .init     (init),
  .init_k   (init_k),
  .coef_out (coef_out)
);

// File: tb/sign_lms_update_tb_top.sv
module sign_lms_update_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT   = 8;
  localparam int CW   = 10;
  localparam int YW   = 12;
  localparam int MUW  = 6;
  localparam int KW   = 9;
  localparam int AMP  = 256;
  localparam int MAIN = 4;
  localparam int CMAX = 511;
  localparam int CMIN = -512;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic              init = 1'b0;
  logic [YW-1:0]     eq_out = '0;
  logic [NT-1:0]     tap_sign = '0;
  logic [MUW-1:0]    step = '0;
  logic [KW-1:0]     init_k = '0;
  logic [NT*CW-1:0]  coef_out;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int mdl[NT];

  logic [NT*CW-1:0] exp_q[$];
  int               due_q[$];
  string            tag_q[$];

  sign_lms_update dut_i (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .eq_out   (eq_out),
    .tap_sign (tap_sign),
    .step     (step),
    .init     (init),
    .init_k   (init_k),
    .coef_out (coef_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [NT*CW-1:0] mdl_vec();
    logic [NT*CW-1:0] v;
    for (int i = 0; i < NT; i++) v[i*CW +: CW] = CW'(mdl[i]);
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [NT*CW-1:0] act,
                           input logic [NT*CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int due, input string tag);
    exp_q.push_back(mdl_vec());
    due_q.push_back(due);
    tag_q.push_back(tag);
  endtask

  // reference model of one sample, built from R4, R5, R6, R8
  task automatic apply_model(input int yv, input logic [NT-1:0] sg, input int mu);
    int lvl;
    int e;
    lvl = (yv >= AMP / 2) ? AMP : ((yv <= -AMP / 2) ? -AMP : 0);
    e   = yv - lvl;
    if (e != 0) begin
      for (int i = 0; i < NT; i++) begin
        if ((e < 0) ^ sg[i]) mdl[i] = (mdl[i] + mu > CMAX) ? CMAX : mdl[i] + mu;
        else                 mdl[i] = (mdl[i] - mu < CMIN) ? CMIN : mdl[i] - mu;
      end
    end
  endtask

  function automatic void set_pattern(input int k);
    for (int i = 0; i < NT; i++) mdl[i] = 0;
    mdl[MAIN]     = 256;
    mdl[MAIN - 1] = -k;
    mdl[MAIN + 1] = -k;
  endfunction

  // driver: one sample; old value due after edge +2, new value after edge +3 (R7)
  task automatic send(input int yv, input logic [NT-1:0] sg, input int mu,
                      input string tag);
    eq_out   = YW'(yv);
    tap_sign = sg;
    step     = MUW'(mu);
    smp_vld  = 1'b1;
    push_exp(cyc + 2, {tag, " / R7 not yet"});
    apply_model(yv, sg, mu);
    push_exp(cyc + 3, tag);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    repeat (2) @(negedge clk);
    repeat (n) begin
      push_exp(cyc + 1, tag);
      @(negedge clk);
    end
  endtask

  task automatic do_init(input int k, input int n);
    init   = 1'b1;
    init_k = KW'(k);
    set_pattern(k);
    repeat (n) begin
      push_exp(cyc + 1, "R2 init pattern");
      @(negedge clk);
    end
    init = 1'b0;
  endtask

  // monitor: compare each queued expectation in its due cycle
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      string            t;
      logic [NT*CW-1:0] e;
      int               d;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      d = due_q.pop_front();
      if (d == cyc) check_vec(t, coef_out, e);
      else          check_vec({t, " (missed due cycle)"}, 'x, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    set_pattern(0);
    check_vec("R1 reset value", coef_out, mdl_vec());
    rst = 1'b0;
    @(negedge clk);
    check_vec("R1 reset value held", coef_out, mdl_vec());

    do_init(40, 3);
    idle(2, "R2 pattern kept");

    // R4 slicer regions and thresholds, R5 direction
    send(300,  8'b1010_0110, 3, "R4 R5 y=300 above +thr");
    send(100,  8'b0110_1001, 3, "R4 R5 y=100 mid region");
    send(-100, 8'b0110_1001, 3, "R4 R5 y=-100 mid region");
    send(128,  8'b1100_0011, 2, "R4 y=128 on +thr");
    send(127,  8'b1100_0011, 2, "R4 y=127 below +thr");
    send(-128, 8'b0011_1100, 4, "R4 y=-128 on -thr");
    send(-127, 8'b0011_1100, 4, "R4 y=-127 above -thr");
    send(-600, 8'b1111_0000, 7, "R4 R5 y=-600 below -thr");
    idle(3, "R7 no valid no change");

    // R6 zero error at each level
    send(256,  8'hFF, 10, "R6 zero error at +level");
    send(0,    8'h00, 10, "R6 zero error at zero");
    send(-256, 8'h5A, 10, "R6 zero error at -level");
    idle(2, "R6 no change");

    // R9, R10 back-to-back samples with changing step
    send(500,  8'hA5, 5,  "R9 R10 step 5");
    send(-700, 8'h3C, 9,  "R9 R10 step 9");
    send(140,  8'h81, 1,  "R9 R10 step 1");
    send(-30,  8'h7E, 33, "R9 R10 step 33");
    idle(2, "R10 settled");

    // R8 saturation both ways
    do_init(0, 1);
    for (int j = 0; j < 12; j++) send(300, 8'hFF, 63, "R8 saturate high");
    for (int j = 0; j < 20; j++) send(300, 8'h00, 63, "R8 saturate low");
    idle(2, "R8 held at limit");

    // R3 sample in flight discarded by one-cycle init
    eq_out   = YW'(300);
    tap_sign = 8'h0F;
    step     = MUW'(20);
    smp_vld  = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    init    = 1'b1;
    init_k  = KW'(33);
    set_pattern(33);
    push_exp(cyc + 1, "R3 init over pending sample");
    push_exp(cyc + 2, "R3 pending sample discarded");
    @(negedge clk);
    init = 1'b0;
    idle(3, "R3 no late update");

    // R3 sample captured with init high
    eq_out   = YW'(-400);
    tap_sign = 8'hC3;
    step     = MUW'(12);
    smp_vld  = 1'b1;
    do_init(12, 1);
    smp_vld = 1'b0;
    idle(3, "R3 sample with init ignored");

    // R2 largest K
    do_init(511, 2);
    send(-300, 8'h18, 6, "R5 after max-K init");
    idle(2, "R2 R7 final");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule